// File: doc/BRIEF.md
# Byte-Lane Static RAM with Address Latch

A cycle-based model of a wide-word static memory. Each word holds 18 bits, split into a high lane and a low lane of 9 bits each, so each lane can carry its own parity bit. The address bus is 16 bits wide. The number of stored words is a parameter, and the word index is the effective address modulo that depth.

An address-hold control lets the address bus either flow straight through or be frozen. When it is high the address passes through. When it is low the last address seen at a rising edge with the control high is held, so the bus can move on to other work.

Two active-low lane selects choose which lanes a read or write touches. Writes commit on the rising clock edge and change only the selected lanes. Read data is combinational from the effective address, so consecutive reads need no extra cycle. The outputs are a data vector and a per-bit drive-enable vector, which together model a three-state bus.

Top module: `byte_sel_sram`

## Requirements
- R1: A word is 18 bits, with the high lane on bits [17:9] and the low lane on bits [8:0]. The 16-bit effective address selects word index (address mod DEPTH), so addresses DEPTH apart refer to the same word.
- R2: While `addr_hold_n` is 1, the effective address equals `addr` in the same cycle. While it is 0, the effective address is the value `addr` had at the last rising edge on which `addr_hold_n` was 1.
- R3: On a rising edge with `cs_n`=0, `wr_n`=0 and at least one of `hi_sel_n`/`lo_sel_n` at 0, the lanes whose select is 0 take the matching bits of `din`. Deselected lanes keep their contents.
- R4: With `rst_n`=1, `cs_n`=0, `wr_n`=1, `rd_en_n`=0 and a lane selected, the selected lane's bits of `dout` equal the stored lane at the effective address in the same cycle, with its `dout_oe` bits all 1. A new address read with `addr_hold_n`=1 shows its data at once.
- R5: With `cs_n`=1, `standby` is 1, nothing is written and `dout_oe` is all 0. With `cs_n`=0, `standby` is 0.
- R6: `dout_oe` is all 0 whenever `rd_en_n` is 1 or `wr_n` is 0, including during a write with `rd_en_n` at 0.
- R7: During a read, a lane whose select is 1 has its `dout_oe` bits and its `dout` bits at 0.
- R8: While `rst_n` is 0, no write takes effect and `dout_oe` is all 0. Reset sets the held address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and address capture occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Word address |
| addr_hold_n | input | 1 | 1: address flows through; 0: held address is used |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low output drive enable |
| hi_sel_n | input | 1 | Active-low select of bits [17:9] |
| lo_sel_n | input | 1 | Active-low select of bits [8:0] |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, 0 on undriven lanes |
| dout_oe | output | 18 | Per-bit output drive enable |
| standby | output | 1 | 1 while the chip is deselected |

## Verification
The assertions assume the control pins are known (not X) and stable around each rising edge, and that reset is held for at least one edge before the first access. The stimulus changes every input one time unit after the rising edge and keeps `rst_n` low at time zero. Every word is written before it is first read, so read data is always defined. After the directed phases, a random phase mixes hold, select and strobe patterns, and a reference model compares the outputs at every falling edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 9;
  localparam int NLANES = 2;
  localparam int WORD_W = LANE_W * NLANES;

  typedef logic [NLANES-1:0] lane_sel_t;
  typedef logic [WORD_W-1:0] word_t;

  // active-low pins -> active-high lane vector, index 1 = high lane
  function automatic lane_sel_t lanes_from_pins(input logic hi_n, input logic lo_n);
    return {~hi_n, ~lo_n};
  endfunction

  // widen a lane vector to a per-bit mask
  function automatic word_t lane_bits(input lane_sel_t sel);
    word_t m;
    for (int l = 0; l < NLANES; l++) m[l*LANE_W +: LANE_W] = {LANE_W{sel[l]}};
    return m;
  endfunction

  function automatic word_t merge_lanes(input word_t old_w, input word_t new_w,
                                        input lane_sel_t sel);
    word_t m;
    m = lane_bits(sel);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/bsram_addr_latch.sv
module bsram_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_eff
);
  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (hold_n) held_q <= addr_in;
  end

  assign addr_eff = hold_n ? addr_in : held_q;

  AST_LATCH_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                       !hold_n |=> (hold_n || $stable(addr_eff)));          // R2
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
                       hold_n |=> (held_q == $past(addr_in)));              // R2
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      wr_n,
  input  logic      rd_en_n,
  input  logic      hi_sel_n,
  input  logic      lo_sel_n,
  output logic      wr_fire,
  output logic      rd_drive,
  output lane_sel_t lanes,
  output logic      standby
);
  logic selected;

  assign lanes    = lanes_from_pins(hi_sel_n, lo_sel_n);
  assign selected = rst_n && !cs_n && (lanes != '0);
  assign wr_fire  = selected && !wr_n;
  assign rd_drive = selected && wr_n && !rd_en_n;
  assign standby  = cs_n;

  AST_NO_RD_WR:       assert property (@(posedge clk) disable iff (!rst_n)
                        !(wr_fire && rd_drive));                            // R3
  AST_WR_NEEDS_LANE:  assert property (@(posedge clk) disable iff (!rst_n)
                        wr_fire |-> ($countones(lanes) > 0) && !cs_n);      // R3
  AST_STANDBY_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                        standby |-> !wr_fire && !rd_drive);                 // R5
endmodule

// File: rtl/bsram_store.sv
module bsram_store
  import bsram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  lane_sel_t        wr_lanes,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= merge_lanes(mem[idx], wdata, wr_lanes);
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/byte_sel_sram.sv
module byte_sel_sram
  import bsram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_hold_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic              hi_sel_n,
  input  logic              lo_sel_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic [WORD_W-1:0] dout_oe,
  output logic              standby
);
  logic [ADDR_W-1:0] addr_eff;
  logic [IDX_W-1:0]  word_idx;
  logic              wr_fire;
  logic              rd_drive;
  lane_sel_t         lanes;
  word_t             rdata;

  bsram_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .hold_n(addr_hold_n),
    .addr_in(addr), .addr_eff(addr_eff)
  );

  bsram_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_en_n(rd_en_n),
    .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
    .wr_fire(wr_fire), .rd_drive(rd_drive), .lanes(lanes), .standby(standby)
  );

  assign word_idx = IDX_W'(int'(addr_eff) % DEPTH);

  bsram_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_fire), .wr_lanes(lanes), .idx(word_idx),
    .wdata(din), .rdata(rdata)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic lane_on;
    assign lane_on = rd_drive && lanes[l];
    assign dout_oe[l*LANE_W +: LANE_W] = {LANE_W{lane_on}};
    assign dout[l*LANE_W +: LANE_W]    = lane_on ? rdata[l*LANE_W +: LANE_W] : '0;
  end

  AST_OE_FLOAT:     assert property (@(posedge clk) disable iff (!rst_n)
                      rd_en_n |-> (dout_oe == '0));                         // R6
  AST_WE_FLOAT:     assert property (@(posedge clk) disable iff (!rst_n)
                      !wr_n |-> (dout_oe == '0));                           // R6
  AST_STANDBY_OFF:  assert property (@(posedge clk) disable iff (!rst_n)
                      cs_n |-> (standby && dout_oe == '0));                 // R5
  AST_HI_LANE_OFF:  assert property (@(posedge clk) disable iff (!rst_n)
                      hi_sel_n |-> (dout_oe[WORD_W-1:LANE_W] == '0
                                    && dout[WORD_W-1:LANE_W] == '0));       // R7
  AST_LO_LANE_OFF:  assert property (@(posedge clk) disable iff (!rst_n)
                      lo_sel_n |-> (dout_oe[LANE_W-1:0] == '0
                                    && dout[LANE_W-1:0] == '0));            // R7
endmodule

// File: tb/byte_sel_sram_bench.sv
module byte_sel_sram_bench;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        addr_hold_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        rd_en_n = 1'b1;
  logic        hi_sel_n = 1'b1;
  logic        lo_sel_n = 1'b1;
  logic [17:0] din = '0;
  logic [17:0] dout, dout_oe;
  logic        standby;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R8";

  // reference state
  logic [17:0] m_mem [DEPTH];
  logic [15:0] m_held = '0;

  byte_sel_sram #(.DEPTH(DEPTH)) u_byte_sel_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_hold_n(addr_hold_n),
    .cs_n(cs_n), .wr_n(wr_n), .rd_en_n(rd_en_n), .hi_sel_n(hi_sel_n),
    .lo_sel_n(lo_sel_n), .din(din), .dout(dout), .dout_oe(dout_oe),
    .standby(standby)
  );

  always #4 clk = ~clk;

  // model update at the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_held <= '0;
    else begin
      int a;
      a = addr_hold_n ? int'(addr) : int'(m_held);
      if (!cs_n && !wr_n && (!hi_sel_n || !lo_sel_n)) begin
        if (!hi_sel_n) m_mem[a % DEPTH][17:9] <= din[17:9];
        if (!lo_sel_n) m_mem[a % DEPTH][8:0]  <= din[8:0];
      end
      if (addr_hold_n) m_held <= addr;
    end
  end

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    int a;
    logic rd;
    logic [17:0] e_oe, e_d;
    a  = addr_hold_n ? int'(addr) : int'(m_held);
    rd = rst_n && !cs_n && wr_n && !rd_en_n && (!hi_sel_n || !lo_sel_n);
    e_oe = {{9{rd && !hi_sel_n}}, {9{rd && !lo_sel_n}}};
    e_d  = e_oe == '0 ? '0 : (m_mem[a % DEPTH] & e_oe);
    n_chk += 3;
    if (standby !== cs_n) begin
      n_bad++; $display("FAIL %s/R5 standby: got %b exp %b", cur_req, standby, cs_n);
    end
    if (dout_oe !== e_oe) begin
      n_bad++; $display("FAIL %s dout_oe: got %h exp %h", cur_req, dout_oe, e_oe);
    end
    if (dout !== e_d) begin
      n_bad++; $display("FAIL %s dout: got %h exp %h", cur_req, dout, e_d);
    end
  end

  task automatic drive(input logic hold, input logic cs, input logic we, input logic oe,
                       input logic hs, input logic ls, input int a, input logic [17:0] d);
    addr_hold_n = hold; cs_n = cs; wr_n = we; rd_en_n = oe;
    hi_sel_n = hs; lo_sel_n = ls; addr = 16'(a); din = d;
    @(posedge clk); #1;
  endtask

  initial begin
    // R8: reset state, outputs quiet
    repeat (3) drive(1, 1, 1, 0, 0, 0, 0, '0);
    rst_n = 1'b1;
    // fill every word
    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 0, 1, 0, 0, i, 18'(i * 4099 + 7));
    // R4: back-to-back reads with flowing address
    cur_req = "R4";
    for (int i = 0; i < DEPTH; i++) drive(1, 0, 1, 0, 0, 0, i, '0);
    // R3: lane-masked writes
    cur_req = "R3";
    drive(1, 0, 0, 1, 0, 1, 4, 18'h3FFFF);
    drive(1, 0, 0, 1, 1, 0, 5, 18'h2AAAA);
    drive(1, 0, 1, 0, 0, 0, 4, '0);
    drive(1, 0, 1, 0, 0, 0, 5, '0);
    // R2: hold address, moving bus
    cur_req = "R2";
    drive(1, 0, 1, 0, 0, 0, 9, '0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 0, 0, 20 + i, '0);
    drive(0, 0, 0, 1, 0, 0, 22, 18'h12345);
    drive(0, 0, 1, 0, 0, 0, 23, '0);
    drive(1, 0, 1, 0, 0, 0, 22, '0);
    // R7: single-lane reads
    cur_req = "R7";
    drive(1, 0, 1, 0, 1, 0, 9, '0);
    drive(1, 0, 1, 0, 0, 1, 9, '0);
    drive(1, 0, 1, 0, 1, 1, 9, '0);
    // R6: floating outputs
    cur_req = "R6";
    drive(1, 0, 1, 1, 0, 0, 9, '0);
    drive(1, 0, 0, 0, 0, 0, 10, 18'h0F0F0);
    drive(1, 0, 1, 0, 0, 0, 10, '0);
    // R5: deselected write ignored
    cur_req = "R5";
    drive(1, 1, 0, 0, 0, 0, 11, 18'h11111);
    drive(1, 0, 1, 0, 0, 0, 11, '0);
    // R1: aliasing across DEPTH
    cur_req = "R1";
    drive(1, 0, 0, 1, 0, 0, 3 + DEPTH, 18'h2BEEF);
    drive(1, 0, 1, 0, 0, 0, 3, '0);
    drive(1, 0, 1, 0, 0, 0, 3 + 7 * DEPTH, '0);
    // R8: write during reset ignored, held address cleared
    cur_req = "R8";
    drive(1, 0, 1, 0, 0, 0, 6, '0);
    rst_n = 1'b0;
    drive(1, 0, 0, 0, 0, 0, 6, 18'h00001);
    rst_n = 1'b1;
    drive(0, 0, 1, 0, 0, 0, 6, '0);
    drive(1, 0, 1, 0, 0, 0, 6, '0);
    // random mix
    cur_req = "R4";
    for (int i = 0; i < 1500; i++)
      drive(1'($urandom), 1'($urandom_range(0, 5) == 0), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom), 1'($urandom), int'($urandom_range(0, 4 * DEPTH)), 18'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end
endmodule